// File: doc/BRIEF.md
# Hardware Semaphore Bank

A bank of hardware mutual-exclusion flags shared by several bus masters, used by processors that must agree on who currently owns a shared resource. Each semaphore is a single register that holds the 4-bit identifier of its current owner, or zero when free. A master takes a semaphore by writing its own identifier into it, reads the register back to learn whether it won, and gives the semaphore up by writing zero. Waiting masters poll; the block raises no interrupt.

Every bus port carries the issuing master's identifier as a sideband. The block uses that sideband to reject forged claims and releases from masters that do not own the semaphore. When several ports hit the same free semaphore in one cycle, a fixed port priority decides the owner. A control register holds the protocol-select bit. The interrupt-clear-all location accepts writes but holds nothing in this polled configuration.

Top module: `hw_semaphore_bank`

## Requirements
- R1: After reset, every semaphore reads zero (free) and the control register reads zero.
- R2: A write to a free semaphore whose data equals the zero-extended, non-zero sideband ID of the writing port makes that ID the owner. Starting with the cycle after the write, a read returns the ID in bits [3:0] and zeros in all higher bits.
- R3: A write to a semaphore held by another master leaves the owner unchanged. A held semaphore never passes directly from one owner to another.
- R4: A write to a free semaphore is ignored when its data differs from the sideband ID. This includes data with any bit set above bit 3, and a sideband ID of zero.
- R5: A write of zero from the port whose sideband ID equals the current owner frees the semaphore. The next read returns zero.
- R6: A write of zero from any master other than the owner is ignored.
- R7: When ports write claims to the same free semaphore in the same cycle, the lowest-numbered port becomes the owner. Claims on different semaphores in the same cycle all succeed.
- R8: Semaphore i sits at byte offset 0x08 + 4*i, for i from 0 to 31. Each semaphore is independent: a claim or release on one leaves all others unchanged.
- R9: The control register at offset 0x00 stores bit 0 from write data. Reads return that bit in bit 0 and zero in bits 31:1.
- R10: Writes to the interrupt-clear-all offset 0x90, to misaligned offsets and to unmapped offsets change no semaphore and no control bit. Reads of all these offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | NPORT | Write enable, one bit per port |
| bus_addr | input | NPORT x AW | Byte address, one per port |
| bus_wdata | input | NPORT x DW | Write data, one per port |
| bus_mid | input | NPORT x IDW | Master ID sideband, one per port |
| bus_rdata | output | NPORT x DW | Combinational read data for the addressed register, one per port |

## Verification
Claims are tried from both ports with matching data, with data that differs only above the ID field, and with a zero ID. This separates the full-word data comparison from a nibble-only comparison. Zero writes come both from the owner and from a stranger, which shows whether a release checks the owner. Simultaneous claims are issued in both ID orders on one semaphore, and on two different semaphores. This distinguishes port priority from ID-value priority and shows that the ports do not block each other. Writes to the first and last semaphores, to misaligned and unmapped offsets, and to the interrupt-clear location show whether the address decode is off by one.

// File: rtl/hw_semaphore_bank.sv
module hw_semaphore_bank #(
  parameter int NPORT     = 2,
  parameter int NSEM      = 32,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int IDW       = 4,
  parameter int SEM_BASE  = 'h08,
  parameter int CTRL_ADDR = 'h00
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0]           bus_we,
  input  logic [NPORT-1:0][AW-1:0]   bus_addr,
  input  logic [NPORT-1:0][DW-1:0]   bus_wdata,
  input  logic [NPORT-1:0][IDW-1:0]  bus_mid,
  output logic [NPORT-1:0][DW-1:0]   bus_rdata
);
  localparam int SEM_END = SEM_BASE + 4 * NSEM;
  localparam int IXW     = (NSEM > 1) ? $clog2(NSEM) : 1;

  logic [NSEM-1:0][IDW-1:0] own_q, own_d;
  logic                     ctrl_q, ctrl_d;
  logic [NPORT-1:0]         sem_hit, ctrl_hit;
  logic [NPORT-1:0][IXW-1:0] sem_ix;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      sem_hit[p]  = (int'(bus_addr[p]) >= SEM_BASE) && (int'(bus_addr[p]) < SEM_END)
                    && (bus_addr[p][1:0] == 2'b00);
      sem_ix[p]   = IXW'((int'(bus_addr[p]) - SEM_BASE) >> 2);
      ctrl_hit[p] = int'(bus_addr[p]) == CTRL_ADDR;
    end
  end

  // Ports walked high to low so the lowest index is applied last and wins.
  always_comb begin
    own_d  = own_q;
    ctrl_d = ctrl_q;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (bus_we[p] && sem_hit[p] && bus_mid[p] != '0) begin
        if (own_q[sem_ix[p]] == '0 && bus_wdata[p] == DW'(bus_mid[p]))
          own_d[sem_ix[p]] = bus_mid[p];
        else if (own_q[sem_ix[p]] == bus_mid[p] && bus_wdata[p] == '0)
          own_d[sem_ix[p]] = '0;
      end
      if (bus_we[p] && ctrl_hit[p])
        ctrl_d = bus_wdata[p][0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      ctrl_q <= 1'b0;
    end else begin
      own_q  <= own_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      bus_rdata[p] = '0;
      if (sem_hit[p])
        bus_rdata[p][IDW-1:0] = own_q[sem_ix[p]];
      else if (ctrl_hit[p])
        bus_rdata[p][0] = ctrl_q;
    end
  end

  generate
    for (genvar i = 0; i < NSEM; i++) begin : g_sem_chk
      p_no_handover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(own_q[i]) != '0 && own_q[i] != $past(own_q[i])) |-> own_q[i] == '0)
        else $error("semaphore %0d changed owner without release", i);

      p_change_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q[i] != $past(own_q[i])) |-> $past(|bus_we))
        else $error("semaphore %0d changed without a write", i);
    end
    for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
      p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[p][DW-1:IDW] == '0)
        else $error("port %0d read data has upper bits set", p);
    end
  endgenerate

  p_ctrl_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> $past(|bus_we))
    else $error("control bit changed without a write");
endmodule

// File: tb/hw_semaphore_bank_test.sv
module hw_semaphore_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // Fields: [52:49] req, [48] port, [47:40] addr, [39:8] wdata, [7:4] mid, [3:0] expected owner
  localparam logic [52:0] VEC [NV] = '{
    {4'd2,  1'b0, 8'h08, 32'h3,  4'h3, 4'h3},  // R2 claim sem0
    {4'd3,  1'b1, 8'h08, 32'h5,  4'h5, 4'h3},  // R3 held, stranger claim
    {4'd6,  1'b1, 8'h08, 32'h0,  4'h5, 4'h3},  // R6 stranger zero write
    {4'd5,  1'b0, 8'h08, 32'h0,  4'h3, 4'h0},  // R5 owner release
    {4'd4,  1'b1, 8'h08, 32'h6,  4'h5, 4'h0},  // R4 data differs from id
    {4'd8,  1'b1, 8'h84, 32'h5,  4'h5, 4'h5},  // R8 last semaphore
    {4'd8,  1'b0, 8'h0C, 32'h2,  4'h2, 4'h2},  // R8 sem1
    {4'd4,  1'b0, 8'h10, 32'h13, 4'h3, 4'h0},  // R4 upper data bit set
    {4'd2,  1'b1, 8'h10, 32'hF,  4'hF, 4'hF},  // R2 max id
    {4'd6,  1'b0, 8'h84, 32'h0,  4'h3, 4'h5},  // R6 stranger release sem31
    {4'd5,  1'b1, 8'h84, 32'h0,  4'h5, 4'h0},  // R5 release sem31
    {4'd10, 1'b0, 8'h88, 32'h7,  4'h7, 4'h0},  // R10 unmapped past end
    {4'd10, 1'b0, 8'h0A, 32'h7,  4'h7, 4'h0},  // R10 misaligned
    {4'd4,  1'b0, 8'h14, 32'h0,  4'h0, 4'h0}   // R4 zero id
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] we = '0;
  logic [1:0][7:0] addr = '0;
  logic [1:0][31:0] wdata = '0;
  logic [1:0][3:0] mid = '0;
  logic [1:0][31:0] rdata;
  int nchk = 0;
  int nfail = 0;

  hw_semaphore_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_mid(mid), .bus_rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int p, input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    we = '0; we[p] = 1'b1; addr[p] = a; wdata[p] = d; mid[p] = m;
    @(negedge clk);
    we = '0;
  endtask

  task automatic wr2(input logic [7:0] a0, input logic [31:0] d0, input logic [3:0] m0,
                     input logic [7:0] a1, input logic [31:0] d1, input logic [3:0] m1);
    @(negedge clk);
    we = 2'b11;
    addr[0] = a0; wdata[0] = d0; mid[0] = m0;
    addr[1] = a1; wdata[1] = d1; mid[1] = m1;
    @(negedge clk);
    we = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    we = '0; addr[0] = a;
    #1 v = rdata[0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    we = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    for (int i = 0; i < 32; i++) begin
      rd(8'(8 + 4 * i), v);
      check("R1", v, 32'h0);
    end
    rd(8'h00, v); check("R1", v, 32'h0);

    for (int k = 0; k < NV; k++) begin
      wr(int'(VEC[k][48]), VEC[k][47:40], VEC[k][39:8], VEC[k][7:4]);
      rd(VEC[k][47:40], v);
      check($sformatf("R%0d vec%0d", VEC[k][52:49], k), v, {28'h0, VEC[k][3:0]});
    end
    // R10 misaligned write did not touch sem0
    rd(8'h08, v); check("R10", v, 32'h0);

    // R7 same semaphore, both id orders
    wr2(8'h18, 32'h4, 4'h4, 8'h18, 32'h9, 4'h9);
    rd(8'h18, v); check("R7", v, 32'h4);
    wr2(8'h1C, 32'hA, 4'hA, 8'h1C, 32'h2, 4'h2);
    rd(8'h1C, v); check("R7", v, 32'hA);
    // R7 different semaphores both succeed
    wr2(8'h20, 32'h1, 4'h1, 8'h24, 32'h2, 4'h2);
    rd(8'h20, v); check("R7", v, 32'h1);
    rd(8'h24, v); check("R7", v, 32'h2);

    // R9 control register
    wr(1, 8'h00, 32'hFFFF_FFFF, 4'h6);
    rd(8'h00, v); check("R9", v, 32'h1);
    wr(0, 8'h00, 32'hFFFF_FFFE, 4'h6);
    rd(8'h00, v); check("R9", v, 32'h0);
    wr(0, 8'h00, 32'h1, 4'h6);

    // R10 interrupt-clear-all write is inert
    wr(0, 8'h90, 32'h0000_FFFF, 4'h2);
    rd(8'h90, v); check("R10", v, 32'h0);
    rd(8'h0C, v); check("R10", v, 32'h2);
    rd(8'h00, v); check("R10", v, 32'h1);

    // R8 independence of the others
    rd(8'h10, v); check("R8", v, 32'hF);
    rd(8'h08, v); check("R8", v, 32'h0);

    // R1 reset mid-run
    do_reset();
    rd(8'h0C, v); check("R1", v, 32'h0);
    rd(8'h00, v); check("R1", v, 32'h0);
    rd(8'h10, v); check("R1", v, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule